// File: doc/BRIEF.md
# CPU Hotplug Selector Register Block

This block gives software a compact, 12-byte little-endian window onto a set of hot-pluggable CPUs. Software first writes the index of one CPU into a selector word. It then reads that CPU's status byte or writes its control byte. A command byte sets the meaning of a shared 32-bit data word. That word can be used to search for a CPU with a pending event, to read back a 64-bit architecture identifier for the chosen CPU, or to log event and status codes for the operating system's status-reporting step.

The host side raises insert events, removal requests and removal acknowledgements on per-CPU strobes. The block keeps four flags for each CPU: enabled, insert pending, remove pending, and firmware eject requested. It raises an interrupt while any event is pending. It emits a one-cycle eject pulse for the selected CPU, and a one-cycle notification that carries the two logged status words.

A selector value outside the range of CPUs blanks the window. Every read returns zero, and every write except one to the selector is dropped. The selector is cleared only at power-up and keeps its value through the functional reset.

Top module: `hpsel_top`

## Requirements
- R1: A read of byte offset 4 returns the selected CPU's status in the low byte of the read data, one cycle after the read strobe: bit 0 enabled, bit 1 insert pending, bit 2 remove pending, bit 4 firmware eject requested, all other bits 0.
- R2: A write to offset 0 stores the full 32-bit value as the selector. While the selector is N_CPU or more, every read returns 0.
- R3: While the selector is N_CPU or more, writes to offsets 4, 5 and 8 have no effect on any flag, the command or the logged status words.
- R4: Power-on reset sets the selector to 0. The functional reset leaves the selector unchanged. The functional reset also clears all event flags and the command, and sets each CPU's enabled bit from the BOOT_MASK parameter.
- R5: A control write to offset 4 clears the selected CPU's insert flag when bit 1 is 1, and clears its remove flag when bit 2 is 1. Other CPUs are unaffected.
- R6: A control write with bit 4 set sets the firmware eject flag. A control write with bit 3 set drives eject_pulse for the selected CPU high for exactly one cycle and clears the firmware eject flag. If bits 3 and 4 are both set, bit 3 wins.
- R7: hp_insert[i] sets CPU i's enabled and insert flags. hp_remove_req[i] sets its remove flag. hp_remove_ack[i] clears its enabled flag.
- R8: Writing command value 0 to offset 5 while any CPU has an insert or remove flag set moves the selector to the lowest such CPU index. Under command 0, offset 8 reads the selector and offset 0 reads 0.
- R9: Writing command 0 when no CPU has a pending event leaves the selector and all flags unchanged.
- R10: Under command 3, offset 8 reads the low 32 bits and offset 0 reads the high 32 bits of the selected CPU's identifier.
- R11: Under command 1, a write to offset 8 stores the event word. Under command 2, a write to offset 8 stores the status word and raises ost_valid for one cycle. While ost_valid is high, ost_event and ost_status show both stored words.
- R12: Offsets other than 0, 4, 5 and 8 read as 0 and ignore writes. Command values other than 0 and 3 make offsets 0 and 8 read as 0.
- R13: irq is high exactly while at least one CPU has its insert or remove flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the selector |
| rst_n | input | 1 | Functional reset, active low, clears flags and command |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 4 | Byte offset within the block |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| cpu_id | input | N_CPU*ID_W | Architecture identifier of each CPU, CPU i at bits i*ID_W |
| hp_insert | input | N_CPU | Host insert event strobes |
| hp_remove_req | input | N_CPU | Host removal request strobes |
| hp_remove_ack | input | N_CPU | Host removal acknowledgement strobes |
| eject_pulse | output | N_CPU | One-cycle eject request for a CPU |
| ost_valid | output | 1 | One-cycle status-log notification |
| ost_event | output | 32 | Logged event word |
| ost_status | output | 32 | Logged status word |
| irq | output | 1 | High while any insert or remove event is pending |

## Verification
Each write takes effect at the clock edge that samples it. The flags, selector, eject_pulse and ost_valid therefore change one edge after the strobe, and irq follows the flags in the same cycle. Read data is registered, so it is valid one edge after the read strobe and is computed from the state that existed before that edge. The bench drives every access on a falling edge and removes it on the next falling edge, which puts exactly one rising edge inside each operation. All results are then sampled on that second falling edge, in the middle of the cycle in which they are due.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;

   // Byte offsets decoded inside the window
   localparam logic [3:0] OFS_SEL  = 4'd0;
   localparam logic [3:0] OFS_STAT = 4'd4;
   localparam logic [3:0] OFS_CMD  = 4'd5;
   localparam logic [3:0] OFS_DATA = 4'd8;

   // Control byte bit positions
   localparam int CTL_CLR_INS = 1;
   localparam int CTL_CLR_REM = 2;
   localparam int CTL_EJECT   = 3;
   localparam int CTL_FW_EJ   = 4;

   typedef enum logic [7:0] {
      CMD_SCAN    = 8'd0,
      CMD_OST_EV  = 8'd1,
      CMD_OST_ST  = 8'd2,
      CMD_ARCH_ID = 8'd3
   } hp_cmd_e;

   typedef struct packed {
      logic fw_ej;
      logic rem;
      logic ins;
      logic en;
   } hp_flags_t;

endpackage

// File: rtl/hpsel_slot.sv
module hpsel_slot
   import hpsel_pkg::*;
#(
   parameter logic BOOT_EN = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      host_ins,
   input  logic      host_rem,
   input  logic      host_ack,
   input  logic      ctl_we,
   input  logic [7:0] ctl_byte,
   output hp_flags_t flags,
   output logic      eject
);

   hp_flags_t nxt;

   always_comb begin
      nxt = flags;
      if (ctl_we) begin
         if (ctl_byte[CTL_CLR_INS]) nxt.ins = 1'b0;
         if (ctl_byte[CTL_CLR_REM]) nxt.rem = 1'b0;
         nxt.fw_ej = (flags.fw_ej | ctl_byte[CTL_FW_EJ]) & ~ctl_byte[CTL_EJECT];
      end
      // host events take precedence over a same-cycle clear
      if (host_ins) begin
         nxt.en  = 1'b1;
         nxt.ins = 1'b1;
      end
      if (host_rem) nxt.rem = 1'b1;
      if (host_ack) nxt.en  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '{fw_ej: 1'b0, rem: 1'b0, ins: 1'b0, en: BOOT_EN};
         eject <= 1'b0;
      end else begin
         flags <= nxt;
         eject <= ctl_we & ctl_byte[CTL_EJECT];
      end
   end

endmodule

// File: rtl/hpsel_find.sv
module hpsel_find #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/hpsel_top.sv
module hpsel_top
   import hpsel_pkg::*;
#(
   parameter int               N_CPU     = 8,
   parameter int               ID_W      = 64,
   parameter logic [N_CPU-1:0] BOOT_MASK = 1
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic                    rst_n,
   input  logic                    acc_en,
   input  logic                    acc_wr,
   input  logic [3:0]              acc_addr,
   input  logic [31:0]             acc_wdata,
   output logic [31:0]             acc_rdata,
   input  logic [N_CPU*ID_W-1:0]   cpu_id,
   input  logic [N_CPU-1:0]        hp_insert,
   input  logic [N_CPU-1:0]        hp_remove_req,
   input  logic [N_CPU-1:0]        hp_remove_ack,
   output logic [N_CPU-1:0]        eject_pulse,
   output logic                    ost_valid,
   output logic [31:0]             ost_event,
   output logic [31:0]             ost_status,
   output logic                    irq
);

   localparam int IW = (N_CPU > 1) ? $clog2(N_CPU) : 1;

   if (N_CPU < 1 || N_CPU > 256) begin : g_bad_ncpu
      $error("hpsel_top: N_CPU must lie in 1..256");
   end
   if (ID_W < 1 || ID_W > 64) begin : g_bad_idw
      $error("hpsel_top: ID_W must lie in 1..64");
   end

   logic [31:0]      sel_q;
   logic [7:0]       cmd_q;
   logic             sel_ok;
   logic [IW-1:0]    sel_idx;
   logic             wr_any, wr_sel, wr_gate, wr_ctl, wr_cmd, wr_dat;
   hp_flags_t        flg [N_CPU];
   logic [N_CPU-1:0] pend;
   logic [63:0]      id_arr [N_CPU];
   logic             scan_any, scan_go;
   logic [IW-1:0]    scan_idx;
   hp_flags_t        sel_flg;
   logic [63:0]      sel_id;
   logic [31:0]      rd_val;

   assign sel_ok  = (sel_q < 32'(N_CPU));
   assign sel_idx = sel_q[IW-1:0];

   assign wr_any  = acc_en & acc_wr & rst_n;
   assign wr_sel  = wr_any & (acc_addr == OFS_SEL);
   assign wr_gate = wr_any & sel_ok;
   assign wr_ctl  = wr_gate & (acc_addr == OFS_STAT);
   assign wr_cmd  = wr_gate & (acc_addr == OFS_CMD);
   assign wr_dat  = wr_gate & (acc_addr == OFS_DATA);

   for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
      hpsel_slot #(.BOOT_EN(BOOT_MASK[g])) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .host_ins (hp_insert[g]),
         .host_rem (hp_remove_req[g]),
         .host_ack (hp_remove_ack[g]),
         .ctl_we   (wr_ctl && (sel_idx == IW'(g))),
         .ctl_byte (acc_wdata[7:0]),
         .flags    (flg[g]),
         .eject    (eject_pulse[g])
      );
      assign pend[g]   = flg[g].ins | flg[g].rem;
      assign id_arr[g] = 64'(cpu_id[g*ID_W +: ID_W]);
   end

   hpsel_find #(.N(N_CPU), .IW(IW)) u_find (
      .req   (pend),
      .found (scan_any),
      .idx   (scan_idx)
   );

   assign scan_go = wr_cmd & (acc_wdata[7:0] == CMD_SCAN) & scan_any;

   // selector lives in the power-on domain only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       sel_q <= '0;
      else if (wr_sel)  sel_q <= acc_wdata;
      else if (scan_go) sel_q <= 32'(scan_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= CMD_SCAN;
         ost_event  <= '0;
         ost_status <= '0;
         ost_valid  <= 1'b0;
      end else begin
         if (wr_cmd) cmd_q <= acc_wdata[7:0];
         if (wr_dat && cmd_q == CMD_OST_EV) ost_event <= acc_wdata;
         if (wr_dat && cmd_q == CMD_OST_ST) ost_status <= acc_wdata;
         ost_valid <= wr_dat && (cmd_q == CMD_OST_ST);
      end
   end

   assign sel_flg = flg[sel_idx];
   assign sel_id  = id_arr[sel_idx];

   always_comb begin
      rd_val = '0;
      if (sel_ok) begin
         case (acc_addr)
            OFS_SEL:  if (cmd_q == CMD_ARCH_ID) rd_val = sel_id[63:32];
            OFS_STAT: rd_val = {27'd0, sel_flg.fw_ej, 1'b0, sel_flg.rem,
                                sel_flg.ins, sel_flg.en};
            OFS_DATA: begin
               if (cmd_q == CMD_SCAN)         rd_val = sel_q;
               else if (cmd_q == CMD_ARCH_ID) rd_val = sel_id[31:0];
            end
            default:  rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_rdata <= '0;
      else        acc_rdata <= (acc_en && !acc_wr) ? rd_val : '0;
   end

   assign irq = |pend;

endmodule

// File: rtl/hpsel_chk.sv
module hpsel_chk #(
   parameter int N_CPU = 8
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             acc_en,
   input logic             acc_wr,
   input logic [3:0]       acc_addr,
   input logic [31:0]      acc_wdata,
   input logic [31:0]      acc_rdata,
   input logic [N_CPU-1:0] hp_insert,
   input logic [N_CPU-1:0] hp_remove_req,
   input logic [N_CPU-1:0] eject_pulse,
   input logic             ost_valid,
   input logic             irq,
   input logic [31:0]      sel_q
);

   AST_EJECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eject_pulse)); // R6

   AST_EJECT_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (|eject_pulse) |-> $past(acc_en && acc_wr && acc_addr == 4'd4 && acc_wdata[3])); // R6

   AST_OST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ost_valid |-> $past(acc_en && acc_wr && acc_addr == 4'd8)); // R11

   AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((|hp_insert) || (|hp_remove_req))); // R13

   AST_BAD_SEL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $past(acc_en && !acc_wr && sel_q >= 32'(N_CPU)) |-> acc_rdata == 32'd0); // R2

   AST_SEL_HELD_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> $stable(sel_q)); // R4

   AST_SCAN_LANDS_VALID: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $past(acc_en && acc_wr && acc_addr == 4'd5 && acc_wdata[7:0] == 8'd0
            && sel_q < 32'(N_CPU) && irq) |-> sel_q < 32'(N_CPU)); // R8

endmodule

bind hpsel_top hpsel_chk #(.N_CPU(N_CPU)) u_chk (
   .clk           (clk),
   .por_n         (por_n),
   .rst_n         (rst_n),
   .acc_en        (acc_en),
   .acc_wr        (acc_wr),
   .acc_addr      (acc_addr),
   .acc_wdata     (acc_wdata),
   .acc_rdata     (acc_rdata),
   .hp_insert     (hp_insert),
   .hp_remove_req (hp_remove_req),
   .eject_pulse   (eject_pulse),
   .ost_valid     (ost_valid),
   .irq           (irq),
   .sel_q         (sel_q)
);

// File: tb/tb_hpsel_top.sv
`timescale 1ns/1ps
module tb_hpsel_top;

   localparam int NC = 8;

   logic            clk = 1'b0;
   logic            por_n, rst_n;
   logic            acc_en, acc_wr;
   logic [3:0]      acc_addr;
   logic [31:0]     acc_wdata, acc_rdata;
   logic [NC*64-1:0] cpu_id;
   logic [NC-1:0]   hp_insert, hp_remove_req, hp_remove_ack, eject_pulse;
   logic            ost_valid, irq;
   logic [31:0]     ost_event, ost_status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model
   logic [NC-1:0] m_en, m_ins, m_rem, m_fw;
   logic [31:0]   m_sel, m_ev, m_st;
   logic [7:0]    m_cmd;

   always #2 clk = ~clk;

   hpsel_top #(.N_CPU(NC), .ID_W(64), .BOOT_MASK(8'h01)) dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .cpu_id(cpu_id),
      .hp_insert(hp_insert), .hp_remove_req(hp_remove_req),
      .hp_remove_ack(hp_remove_ack), .eject_pulse(eject_pulse),
      .ost_valid(ost_valid), .ost_event(ost_event), .ost_status(ost_status),
      .irq(irq)
   );

   function automatic logic [31:0] id_hi(int i);
      return 32'hA000_0000 + 32'(i);
   endfunction

   function automatic logic [31:0] id_lo(int i);
      return 32'h0000_1000 + 32'(i * 3);
   endfunction

   function automatic logic [31:0] exp_read(logic [3:0] a);
      int s;
      if (m_sel >= NC) return 32'd0;
      s = int'(m_sel);
      case (a)
         4'd0: return (m_cmd == 8'd3) ? id_hi(s) : 32'd0;
         4'd4: return {27'd0, m_fw[s], 1'b0, m_rem[s], m_ins[s], m_en[s]};
         4'd8: begin
            if (m_cmd == 8'd0) return m_sel;
            if (m_cmd == 8'd3) return id_lo(s);
            return 32'd0;
         end
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic model_freset();
      m_en = 8'h01; m_ins = '0; m_rem = '0; m_fw = '0;
      m_cmd = 8'd0; m_ev = '0; m_st = '0;
   endtask

   task automatic bus_wr(logic [3:0] a, logic [31:0] d, string rq);
      logic [NC-1:0] exp_ej;
      logic          exp_ov;
      bit            ok;
      exp_ej = '0;
      exp_ov = 1'b0;
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
      ok = (m_sel < NC);
      if (a == 4'd0) m_sel = d;
      else if (ok) begin
         case (a)
            4'd4: begin
               if (d[1]) m_ins[m_sel] = 1'b0;
               if (d[2]) m_rem[m_sel] = 1'b0;
               m_fw[m_sel] = (m_fw[m_sel] | d[4]) & ~d[3];
               exp_ej[m_sel] = d[3];
            end
            4'd5: begin
               m_cmd = d[7:0];
               if (d[7:0] == 8'd0) begin
                  for (int i = NC - 1; i >= 0; i--)
                     if (m_ins[i] | m_rem[i]) m_sel = 32'(i);
               end
            end
            4'd8: begin
               if (m_cmd == 8'd1) m_ev = d;
               if (m_cmd == 8'd2) begin m_st = d; exp_ov = 1'b1; end
            end
            default: ;
         endcase
      end
      check({rq, "/R6 eject"}, 32'(eject_pulse), 32'(exp_ej));
      check({rq, "/R11 ost_valid"}, 32'(ost_valid), 32'(exp_ov));
      if (exp_ov) begin
         check("R11 ost_event", ost_event, m_ev);
         check("R11 ost_status", ost_status, m_st);
      end
      check({rq, "/R13 irq"}, 32'(irq), 32'(|(m_ins | m_rem)));
   endtask

   task automatic bus_rd(logic [3:0] a, string rq);
      logic [31:0] e;
      e = exp_read(a);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_en = 1'b0;
      check(rq, acc_rdata, e);
   endtask

   task automatic host(int kind, int idx);
      @(negedge clk);
      if (kind == 0) hp_insert[idx] = 1'b1;
      else if (kind == 1) hp_remove_req[idx] = 1'b1;
      else hp_remove_ack[idx] = 1'b1;
      @(negedge clk);
      hp_insert = '0; hp_remove_req = '0; hp_remove_ack = '0;
      if (kind == 0) begin m_en[idx] = 1'b1; m_ins[idx] = 1'b1; end
      else if (kind == 1) m_rem[idx] = 1'b1;
      else m_en[idx] = 1'b0;
      check("R7/R13 irq after host event", 32'(irq), 32'(|(m_ins | m_rem)));
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [3:0] ra [5];
      ra[0] = 4'd0; ra[1] = 4'd4; ra[2] = 4'd5; ra[3] = 4'd8; ra[4] = 4'd6;
      por_n = 1'b0; rst_n = 1'b0;
      acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
      hp_insert = '0; hp_remove_req = '0; hp_remove_ack = '0;
      for (int i = 0; i < NC; i++) cpu_id[i*64 +: 64] = {id_hi(i), id_lo(i)};
      m_sel = '0;
      model_freset();
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;

      // reset state
      check("R4 reset irq", 32'(irq), 32'd0);
      bus_rd(4'd4, "R1/R4 reset status of boot CPU");
      bus_rd(4'd8, "R4 reset selector 0 under command 0");

      // scan with nothing pending
      bus_wr(4'd0, 32'd3, "R2 select 3");
      bus_wr(4'd5, 32'd0, "R9 scan none");
      bus_rd(4'd8, "R9 selector unchanged");
      bus_rd(4'd4, "R9 flags unchanged");

      // host events and scan
      host(0, 5);
      host(0, 2);
      bus_wr(4'd0, 32'd7, "R2 select 7");
      bus_wr(4'd5, 32'd0, "R8 scan");
      bus_rd(4'd8, "R8 scan picks lowest");
      bus_rd(4'd0, "R8 data-2 reads 0");
      bus_rd(4'd4, "R1/R7 status after insert");

      // control clears
      bus_wr(4'd4, 32'h02, "R5 clear insert");
      bus_rd(4'd4, "R5 insert cleared");
      bus_wr(4'd0, 32'd5, "R2 select 5");
      bus_rd(4'd4, "R5 other CPU untouched");

      // eject handling
      bus_wr(4'd4, 32'h10, "R6 firmware eject request");
      bus_rd(4'd4, "R6 firmware flag set");
      bus_wr(4'd4, 32'h08, "R6 start eject");
      bus_rd(4'd4, "R6 firmware flag cleared");
      bus_wr(4'd4, 32'h18, "R6 both bits");
      bus_rd(4'd4, "R6 eject wins");
      host(1, 5);
      bus_rd(4'd4, "R7 remove pending");
      host(2, 5);
      bus_rd(4'd4, "R7 enabled cleared by ack");
      bus_wr(4'd4, 32'h06, "R5 clear both");
      bus_rd(4'd4, "R5 both cleared");

      // identifier
      bus_wr(4'd5, 32'd3, "R10 command id");
      bus_rd(4'd8, "R10 id low");
      bus_rd(4'd0, "R10 id high");

      // status logging
      bus_wr(4'd5, 32'd1, "R11 command event");
      bus_wr(4'd8, 32'hCAFE_0001, "R11 write event");
      bus_wr(4'd5, 32'd2, "R11 command status");
      bus_wr(4'd8, 32'h0000_BEEF, "R11 write status");

      // invalid selector
      bus_wr(4'd5, 32'd3, "R10 command id again");
      bus_wr(4'd0, 32'd100, "R2 invalid selector");
      bus_rd(4'd4, "R2 blank status");
      bus_rd(4'd0, "R2 blank data-2");
      bus_wr(4'd5, 32'd0, "R3 command dropped");
      bus_wr(4'd4, 32'h10, "R3 control dropped");
      bus_wr(4'd0, 32'd5, "R2 back to 5");
      bus_rd(4'd0, "R3 command kept");
      bus_rd(4'd4, "R3 flags kept");

      // reserved offsets and commands
      bus_rd(4'd6, "R12 reserved offset reads 0");
      bus_wr(4'd6, 32'hFFFF_FFFF, "R12 reserved write");
      bus_rd(4'd4, "R12 no effect on flags");
      bus_wr(4'd5, 32'd7, "R12 reserved command");
      bus_rd(4'd8, "R12 reserved command data");
      bus_rd(4'd0, "R12 reserved command data-2");

      // functional reset keeps selector
      host(0, 6);
      bus_wr(4'd0, 32'd4, "R4 select 4");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      model_freset();
      check("R4 irq after reset", 32'(irq), 32'd0);
      bus_rd(4'd8, "R4 selector kept");
      bus_wr(4'd0, 32'd0, "R4 select 0");
      bus_rd(4'd4, "R4 boot enable restored");

      // constrained random
      void'($urandom(32'd4242));
      for (int k = 0; k < 500; k++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0: host(int'($urandom % 3), int'($urandom % NC));
            1: bus_wr(4'd0, 32'($urandom % 10), "R2 random select");
            2: bus_wr(4'd4, 32'($urandom) & 32'h1E, "R5 random control");
            3: bus_wr(4'd5, 32'($urandom % 5), "R8 random command");
            4: bus_wr(4'd8, $urandom, "R11 random data");
            default: bus_rd(ra[$urandom % 5], "R1 random read");
         endcase
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule